// File: doc/BRIEF.md
# Configurable UART Character Framer

This block turns parallel bytes into asynchronous serial characters and turns serial characters back into bytes. A character has one low start bit, then 5 to 8 data bits with bit 0 first, then an optional parity bit and a high stop interval. The transmitter takes a byte through a valid/ready handshake and shifts it out on `txd`. The receiver watches its line, rejects start edges that do not last, and delivers each character as a one-cycle pulse with parity, framing and break flags.

Timing comes from an oversample tick that runs at 16 times the bit rate. The tick is derived from the clock by a programmable divisor, optionally preceded by a divide-by-4 prescaler. The prescaler bit is loaded from the inverse of a select pin while reset is held, and a write strobe can change it later. The transmitter can force a break (continuous low). A loopback mode feeds the internal transmit line into the receiver for self-test.

Top module: `uart_framer`

## Requirements
- R1: `char_len` values 0,1,2,3 select 5,6,7,8 data bits; transmit ignores `tx_data` bits at and above the length, and received bytes carry zeros in those bits.
- R2: A character on the line is a low start bit, the data bits with bit 0 first, the parity bit when enabled, then a high stop interval; each bit lasts 16 ticks.
- R3: `parity_mode` 01 selects odd parity and 10 selects even parity (the parity bit makes the count of ones in data plus parity odd or even); 00 and 11 send no parity bit.
- R4: The receiver sets `rx_parity_err` with a character whose received parity bit disagrees with the selected mode; it stays clear when parity is off or correct.
- R5: `stop_mode` 00, 01 and 10/11 give a transmit stop interval of 16, 24 and 32 ticks; with a divisor of 1 `tx_ready` returns exactly 16*(1+bits+parity)+stop clocks after the accepting edge.
- R6: While `force_break` is high and loopback is off, `txd` is low; with no character in flight and no break, `txd` is high.
- R7: A character received while the line stayed low through the data, parity and first stop sample is reported with `rx_break`, `rx_frame_err` and zero data; one report per break, and the receiver waits for the line to go high again.
- R8: A low first stop sample sets `rx_frame_err`; each character is delivered as a `rx_valid` pulse of one clock.
- R9: A low pulse on the receive line that is high again at the half-bit sample (8 ticks after detection) produces no character.
- R10: The tick period in clocks is max(`divisor`,1), times 4 when the prescaler bit is set.
- R11: During reset the prescaler bit takes the inverse of `presc_sel_pin` (pin high: divide by 1, pin low: divide by 4); a cycle with `presc_wr` high loads `presc_wr_div4` into it.
- R12: With `loopback` high the receiver takes the internal transmit line, `rxd` is ignored and `txd` is held high.
- R13: `tx_ready` is high when no character is in flight; a byte is accepted on a clock edge with `tx_valid` and `tx_ready` both high, and the start bit appears on `txd` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_sel_pin | input | 1 | Select pin sampled inverted into the prescaler bit during reset |
| presc_wr | input | 1 | Load strobe for the prescaler bit |
| presc_wr_div4 | input | 1 | Value loaded by `presc_wr` (1 = divide by 4) |
| divisor | input | DIV_W | Tick divisor, 0 treated as 1 |
| char_len | input | 2 | Data bit count select |
| parity_mode | input | 2 | Parity select |
| stop_mode | input | 2 | Stop interval select |
| force_break | input | 1 | Hold the transmit line low |
| loopback | input | 1 | Route transmit line to receiver |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle, byte can be accepted |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse, received character available |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on this character |
| rx_frame_err | output | 1 | First stop sample was low |
| rx_break | output | 1 | Line low for the whole character |

## Verification
The bench builds the block with its default widths (16-bit divisor, 16 ticks per bit) and mostly runs a divisor of 1, so one tick is one clock and every bit edge, stop length and sample point lands on a clock the bench can predict exactly. Divisors of 3 and 0 and both prescaler states are then exercised by measuring the start-bit length, which separates divide-by-1 from divide-by-4 with no overlap. This keeps whole frames to a few hundred clocks, leaving room for every character length, parity mode, stop length, break, false start and loopback case.

// File: rtl/uart_framer.sv
module uart_framer #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             presc_sel_pin,
  input  logic             presc_wr,
  input  logic             presc_wr_div4,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic [1:0]       parity_mode,
  input  logic [1:0]       stop_mode,
  input  logic             force_break,
  input  logic             loopback,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_parity_err,
  output logic             rx_frame_err,
  output logic             rx_break
);

  localparam int CW = $clog2(2*OVS);
  localparam logic [CW-1:0] BIT_M1   = CW'(OVS-1);
  localparam logic [CW-1:0] HALF_M1  = CW'(OVS/2-1);
  localparam logic [CW-1:0] STOP15_M1 = CW'(OVS+OVS/2-1);
  localparam logic [CW-1:0] STOP2_M1 = CW'(2*OVS-1);

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP, PH_WAIT} phase_t;

  // tick generation
  logic             div4;
  logic [1:0]       pcnt;
  logic [DIV_W-1:0] bcnt, div_m1;
  logic             pre_tick, tick;

  assign div_m1   = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign pre_tick = !div4 || (pcnt == 2'd3);
  assign tick     = pre_tick && (bcnt >= div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div4 <= ~presc_sel_pin;
      pcnt <= '0;
      bcnt <= '0;
    end else begin
      if (presc_wr) div4 <= presc_wr_div4;
      pcnt <= pcnt + 2'd1;
      if (pre_tick) bcnt <= tick ? '0 : bcnt + DIV_W'(1);
    end
  end

  // configuration decode
  logic [2:0]    cfg_nb_m1;
  logic [7:0]    cfg_mask;
  logic          cfg_pen, cfg_odd;
  logic [CW-1:0] cfg_stop_m1;

  assign cfg_nb_m1 = 3'd4 + {1'b0, char_len};
  assign cfg_mask  = 8'hFF >> (3'd7 - cfg_nb_m1);
  assign cfg_pen   = (parity_mode == 2'b01) || (parity_mode == 2'b10);
  assign cfg_odd   = (parity_mode == 2'b01);

  always_comb begin
    case (stop_mode)
      2'b00:   cfg_stop_m1 = BIT_M1;
      2'b01:   cfg_stop_m1 = STOP15_M1;
      default: cfg_stop_m1 = STOP2_M1;
    endcase
  end

  // transmitter
  phase_t        tx_ph;
  logic [CW-1:0] tx_cnt, tx_stop_m1, tx_lim;
  logic [2:0]    tx_idx, tx_nb_m1;
  logic [7:0]    tx_sh;
  logic          tx_pen, tx_pbit, tx_line, tx_wire;

  assign tx_ready = (tx_ph == PH_IDLE);
  assign tx_lim   = (tx_ph == PH_STOP) ? tx_stop_m1 : BIT_M1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ph      <= PH_IDLE;
      tx_cnt     <= '0;
      tx_idx     <= '0;
      tx_sh      <= '0;
      tx_nb_m1   <= '0;
      tx_pen     <= 1'b0;
      tx_pbit    <= 1'b0;
      tx_stop_m1 <= BIT_M1;
    end else if (tx_ph == PH_IDLE) begin
      if (tx_valid) begin
        tx_ph      <= PH_START;
        tx_cnt     <= '0;
        tx_idx     <= '0;
        tx_sh      <= tx_data & cfg_mask;
        tx_nb_m1   <= cfg_nb_m1;
        tx_pen     <= cfg_pen;
        tx_pbit    <= (^(tx_data & cfg_mask)) ^ cfg_odd;
        tx_stop_m1 <= cfg_stop_m1;
      end
    end else if (tick) begin
      if (tx_cnt != tx_lim) begin
        tx_cnt <= tx_cnt + CW'(1);
      end else begin
        tx_cnt <= '0;
        case (tx_ph)
          PH_START: tx_ph <= PH_DATA;
          PH_DATA: begin
            tx_sh <= tx_sh >> 1;
            if (tx_idx == tx_nb_m1) tx_ph <= tx_pen ? PH_PAR : PH_STOP;
            else tx_idx <= tx_idx + 3'd1;
          end
          PH_PAR:  tx_ph <= PH_STOP;
          default: tx_ph <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (tx_ph)
      PH_START: tx_line = 1'b0;
      PH_DATA:  tx_line = tx_sh[0];
      PH_PAR:   tx_line = tx_pbit;
      default:  tx_line = 1'b1;
    endcase
  end

  assign tx_wire = force_break ? 1'b0 : tx_line;
  assign txd     = loopback ? 1'b1 : tx_wire;

  // receiver
  phase_t        rx_ph;
  logic          rx_q1, rx_q2;
  logic [CW-1:0] rx_cnt, rx_lim;
  logic [2:0]    rx_idx, rx_nb_m1;
  logic [7:0]    rx_sh;
  logic          rx_pen, rx_odd, rx_pbit, rx_zero, rx_center;

  assign rx_lim    = (rx_ph == PH_START) ? HALF_M1 : BIT_M1;
  assign rx_center = tick && (rx_cnt == rx_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_q2 <= 1'b1;
    end else begin
      rx_q1 <= loopback ? tx_wire : rxd;
      rx_q2 <= rx_q1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ph         <= PH_IDLE;
      rx_cnt        <= '0;
      rx_idx        <= '0;
      rx_sh         <= '0;
      rx_nb_m1      <= '0;
      rx_pen        <= 1'b0;
      rx_odd        <= 1'b0;
      rx_pbit       <= 1'b0;
      rx_zero       <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_break      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (rx_ph)
        PH_IDLE: if (!rx_q2) begin
          rx_ph    <= PH_START;
          rx_cnt   <= '0;
          rx_sh    <= '0;
          rx_zero  <= 1'b1;
          rx_nb_m1 <= cfg_nb_m1;
          rx_pen   <= cfg_pen;
          rx_odd   <= cfg_odd;
        end
        PH_WAIT: if (rx_q2) rx_ph <= PH_IDLE;
        default: if (tick) begin
          if (!rx_center) begin
            rx_cnt <= rx_cnt + CW'(1);
          end else begin
            rx_cnt <= '0;
            case (rx_ph)
              PH_START: begin
                rx_idx <= '0;
                rx_ph  <= rx_q2 ? PH_IDLE : PH_DATA;
              end
              PH_DATA: begin
                rx_sh[rx_idx] <= rx_q2;
                rx_zero       <= rx_zero & ~rx_q2;
                if (rx_idx == rx_nb_m1) rx_ph <= rx_pen ? PH_PAR : PH_STOP;
                else rx_idx <= rx_idx + 3'd1;
              end
              PH_PAR: begin
                rx_pbit <= rx_q2;
                rx_zero <= rx_zero & ~rx_q2;
                rx_ph   <= PH_STOP;
              end
              default: begin
                rx_valid      <= 1'b1;
                rx_data       <= rx_sh;
                rx_frame_err  <= ~rx_q2;
                rx_break      <= ~rx_q2 & rx_zero;
                rx_parity_err <= rx_pen && (rx_pbit != ((^rx_sh) ^ rx_odd));
                rx_ph         <= rx_q2 ? PH_IDLE : PH_WAIT;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

module uart_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       presc_sel_pin,
  input logic       div4,
  input logic [1:0] char_len,
  input logic       force_break,
  input logic       loopback,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_frame_err,
  input logic       rx_break
);

  p_presc_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (div4 == !$past(presc_sel_pin)));

  p_start_after_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !loopback && !force_break) |=> (!tx_ready && (loopback || !txd)));

  p_idle_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && $past(tx_ready) && $stable(force_break) && $stable(loopback)) |-> $stable(txd));

  p_rx_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> (4'd5 + {2'b00, char_len})) == 8'd0));

  p_break_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> (rx_frame_err && rx_data == 8'd0));

endmodule

bind uart_framer uart_framer_chk chk_i (.*);

// File: tb/uart_framer_tb_top.sv
module uart_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       presc_sel_pin = 1'b1;
  logic       presc_wr = 1'b0;
  logic       presc_wr_div4 = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] char_len = 2'd3;
  logic [1:0] parity_mode = 2'd0;
  logic [1:0] stop_mode = 2'd0;
  logic       force_break = 1'b0;
  logic       loopback = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_ready, txd;
  logic       rxd = 1'b1;
  logic       rx_valid, rx_parity_err, rx_frame_err, rx_break;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, got_n = 0;
  logic [7:0] got_d;
  logic got_pe, got_fe, got_br;
  bit done = 0;

  always #5 clk = ~clk;

  uart_framer dut_i (.*);

  always @(negedge clk) if (rx_valid) begin
    got_n++; got_d = rx_data; got_pe = rx_parity_err; got_fe = rx_frame_err; got_br = rx_break;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk); rst_n = 1'b0; presc_sel_pin = pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic par_bit(input logic [7:0] d, input int n, input logic [1:0] pm);
    logic x = 1'b0;
    for (int i = 0; i < n; i++) x ^= d[i];
    return (pm == 2'b01) ? ~x : x;
  endfunction

  task automatic t_reset_state();
    chk("R13 reset tx_ready", tx_ready, 1);
    chk("R6 reset txd idle high", txd, 1);
    chk("R8 reset rx_valid", rx_valid, 0);
  endtask

  // divisor 1: one tick per clock
  task automatic t_tx(input string tag, input logic [7:0] d, input logic [1:0] cl,
                      input logic [1:0] pm, input logic [1:0] sm);
    int n, p, nt, stop, cnt;
    logic [11:0] got, exp;
    n = 5 + cl; p = (pm == 2'b01 || pm == 2'b10) ? 1 : 0;
    stop = (sm == 0) ? 16 : (sm == 1) ? 24 : 32;
    nt = 2 + n + p;
    exp = '0; got = '0;
    for (int i = 0; i < n; i++) exp[1+i] = d[i];
    if (p == 1) exp[1+n] = par_bit(d, n, pm);
    exp[1+n+p] = 1'b1;
    char_len = cl; parity_mode = pm; stop_mode = sm;
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
    chk({tag, " R13 busy after accept"}, tx_ready, 0);
    cnt = 0;
    while (!tx_ready && cnt < 4000) begin
      if (cnt % 16 == 8 && cnt / 16 < nt) got[cnt/16] = txd;
      @(negedge clk); cnt++;
    end
    chk({tag, " R2 R3 line bits"}, got, exp);
    chk({tag, " R5 frame clocks"}, cnt, 16*(1+n+p) + stop);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_rx(input string tag, input logic [7:0] d, input logic [1:0] cl, input logic [1:0] pm,
                      input logic flip, input logic stop_low, input logic [7:0] exp_d,
                      input logic exp_pe);
    int n, base;
    n = 5 + cl;
    char_len = cl; parity_mode = pm;
    base = got_n;
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (pm == 2'b01 || pm == 2'b10) drive_bit(par_bit(d, n, pm) ^ flip);
    drive_bit(!stop_low);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk({tag, " R8 one character"}, got_n - base, 1);
    chk({tag, " R1 R2 data"}, got_d, exp_d);
    chk({tag, " R4 parity flag"}, got_pe, exp_pe);
    chk({tag, " R8 frame flag"}, got_fe, stop_low);
    chk({tag, " R7 no break"}, got_br, 0);
  endtask

  task automatic t_rx_break();
    int base;
    char_len = 2'd3; parity_mode = 2'd0;
    base = got_n;
    @(negedge clk); rxd = 1'b0;
    repeat (16*14) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk("R7 break single report", got_n - base, 1);
    chk("R7 break flag", got_br, 1);
    chk("R7 break frame flag", got_fe, 1);
    chk("R7 break data", got_d, 0);
  endtask

  task automatic t_false_start();
    int base;
    base = got_n;
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (250) @(negedge clk);
    chk("R9 false start rejected", got_n - base, 0);
  endtask

  task automatic t_tx_break();
    @(negedge clk); force_break = 1'b1;
    #1 chk("R6 forced break low", txd, 0);
    @(negedge clk); force_break = 1'b0;
    #1 chk("R6 break released high", txd, 1);
  endtask

  task automatic t_loopback();
    int base, lows, cnt;
    char_len = 2'd3; parity_mode = 2'b10; stop_mode = 2'd0;
    @(negedge clk); loopback = 1'b1; rxd = 1'b0;
    base = got_n;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA3;
    @(negedge clk); tx_valid = 1'b0;
    lows = 0; cnt = 0;
    while (!tx_ready && cnt < 4000) begin
      if (!txd) lows++;
      @(negedge clk); cnt++;
    end
    repeat (40) @(negedge clk);
    chk("R12 txd held high", lows, 0);
    chk("R12 looped character", got_n - base, 1);
    chk("R12 looped data", got_d, 8'hA3);
    chk("R12 looped no errors", {got_pe, got_fe, got_br}, 0);
    rxd = 1'b1;
    @(negedge clk); loopback = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_start_len(input string tag, input logic [15:0] dv, input int lo, input int hi);
    int cnt;
    divisor = dv; char_len = 2'd3; parity_mode = 2'd0; stop_mode = 2'd0;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hFF;
    @(negedge clk); tx_valid = 1'b0;
    cnt = 0;
    while (!txd && cnt < 4000) begin
      @(negedge clk); cnt++;
    end
    chk_rng(tag, cnt, lo, hi);
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    t_reset_state();
    t_tx("8N1", 8'hC5, 2'd3, 2'b00, 2'b00);
    t_tx("7E2", 8'h5B, 2'd2, 2'b10, 2'b10);
    t_tx("6O1.5", 8'h2D, 2'd1, 2'b01, 2'b01);
    t_tx("5N2 upper ignored R1", 8'hE9, 2'd0, 2'b11, 2'b11);
    t_rx("rx 8N", 8'h96, 2'd3, 2'b00, 1'b0, 1'b0, 8'h96, 1'b0);
    t_rx("rx 7E ok", 8'h3A, 2'd2, 2'b10, 1'b0, 1'b0, 8'h3A, 1'b0);
    t_rx("rx 7O bad", 8'h3A, 2'd2, 2'b01, 1'b1, 1'b0, 8'h3A, 1'b1);
    t_rx("rx 5N", 8'h15, 2'd0, 2'b00, 1'b0, 1'b0, 8'h15, 1'b0);
    t_rx("rx framing", 8'h55, 2'd3, 2'b00, 1'b0, 1'b1, 8'h55, 1'b0);
    t_rx_break();
    t_false_start();
    t_rx("rx after false start R9", 8'h81, 2'd3, 2'b00, 1'b0, 1'b0, 8'h81, 1'b0);
    t_tx_break();
    t_loopback();
    t_start_len("R10 divisor 3 start bit", 16'd3, 46, 48);
    t_start_len("R10 divisor 0 start bit", 16'd0, 16, 16);
    do_reset(1'b0);
    t_start_len("R11 pin low gives div4", 16'd3, 181, 192);
    @(negedge clk); presc_wr = 1'b1; presc_wr_div4 = 1'b0;
    @(negedge clk); presc_wr = 1'b0;
    t_start_len("R11 write back to div1", 16'd3, 46, 48);
    divisor = 16'd1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule